// File: doc/BRIEF.md
# T1 Overhead Bit Receive Deserializer

This block gathers the overhead bits recovered from an incoming T1 stream into a byte that a host can read. In extended-superframe operation those bits are the facility data link bits. In superframe (D4) operation they are the Fs framing bits. Each bit arrives on `rx_bit` together with a one-cycle `bit_strobe`. The bits enter least significant first. Framing recovery elsewhere in the receiver supplies the strobe and, for D4, a pulse that marks the end of each multiframe.

In extended-superframe mode a byte is complete after every eighth strobe. The byte is copied into the held data register and a latched full flag is raised. At one bit per 250 µs, this repeats every 2 ms. In D4 mode the strobed bits collect in a six-bit shifter, and the held register is loaded only on the multiframe pulse. The bits are passed on exactly as received, with no zero destuffing. The host clears the full flag by writing a one to it. A byte that is not read before the next one completes is overwritten, and a sticky overrun flag records the loss. An active-low interrupt follows the full flag when the mask enable is set.

Top module: `t1_oh_rx_deser`

## Requirements
- R1: Bits enter least significant first. The first strobed bit of a byte lands in `rx_data[0]`, and in extended-superframe mode the eighth lands in `rx_data[7]`.
- R2: In extended-superframe mode (`d4_mode`=0), the clock edge that takes the eighth strobed bit loads `rx_data` and sets `full_flag`. Both are visible in the cycle after that edge.
- R3: Bits are delivered raw. A run of five or more ones followed by a zero appears in `rx_data` unchanged, and no bit is removed.
- R4: `irq_n` is low exactly when `full_flag` is 1 and `irq_en` is 1. Otherwise `irq_n` is high.
- R5: In D4 mode (`d4_mode`=1), `rx_data` changes only on the edge where `mf_boundary` is high. At that edge `rx_data[5:0]` takes the last six strobed Fs bits, first bit in bit 0, and `rx_data[7:6]` reads 0. In extended-superframe mode `mf_boundary` has no effect.
- R6: If a byte completes while `full_flag` is already 1 and `clr_full` is 0, the new byte overwrites `rx_data` and `ovr_flag` is set. `ovr_flag` stays set until `clr_ovr` is pulsed.
- R7: A cycle with `clr_full`=1 clears `full_flag`. If a byte completes in the same cycle, `full_flag` stays 1.
- R8: Reset gives `rx_data`=0, `full_flag`=0, `ovr_flag`=0 and `irq_n`=1. Between completions `rx_data` holds its value.
- R9: A change of `d4_mode` discards the partial byte. No byte completes in that cycle, and counting restarts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d4_mode | input | 1 | 1: D4 Fs bits, 0: extended-superframe data link bits |
| rx_bit | input | 1 | Recovered overhead bit |
| bit_strobe | input | 1 | `rx_bit` is valid this cycle |
| mf_boundary | input | 1 | End-of-multiframe pulse, used in D4 mode |
| clr_full | input | 1 | Write-one-to-clear for `full_flag` |
| clr_ovr | input | 1 | Write-one-to-clear for `ovr_flag` |
| irq_en | input | 1 | Interrupt mask enable |
| rx_data | output | 8 | Held received byte |
| full_flag | output | 1 | Latched buffer-full status |
| ovr_flag | output | 1 | Sticky overrun status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A bit counter that slips by one shows at the ports within a single byte time. The full flag rises one strobe early or late, and the captured byte comes out rotated. For that reason every byte in the stimulus is asymmetric. A shifter that loses D4 alignment or leaks bits into the top two positions shows on the very next multiframe pulse as a nonzero `rx_data[7:6]` or a wrong Fs pattern. A flag error (a lost set-over-clear, or a missing overrun) shows one cycle after the completing strobe, on `full_flag`, `ovr_flag` or `irq_n`.

// File: rtl/t1_oh_rx_deser.sv
module t1_oh_rx_deser #(
  parameter int BYTE_W  = 8,
  parameter int D4_W    = 6,
  parameter bit HAS_OVR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d4_mode,
  input  logic              rx_bit,
  input  logic              bit_strobe,
  input  logic              mf_boundary,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              irq_en,
  output logic [BYTE_W-1:0] rx_data,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              irq_n
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] D4_MASK = (BYTE_W'(1) << D4_W) - BYTE_W'(1);

  logic [BYTE_W-1:0] sh, sh_nxt;
  logic [CNT_W-1:0]  cnt;
  logic              mode_q, mode_chg, cap;

  assign mode_chg = d4_mode != mode_q;
  assign cap = !mode_chg &&
               (d4_mode ? mf_boundary
                        : (bit_strobe && cnt == CNT_W'(BYTE_W-1)));

  always_comb begin
    sh_nxt = sh;
    if (bit_strobe) begin
      sh_nxt = sh >> 1;
      if (d4_mode) sh_nxt[D4_W-1]   = rx_bit;
      else         sh_nxt[BYTE_W-1] = rx_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      mode_q  <= 1'b0;
      rx_data <= '0;
    end else begin
      mode_q <= d4_mode;
      if (mode_chg) begin
        sh  <= '0;
        cnt <= '0;
      end else begin
        sh <= sh_nxt;
        if (bit_strobe && !d4_mode) cnt <= cnt + 1'b1;
        if (cap) rx_data <= d4_mode ? (sh_nxt & D4_MASK) : sh_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        full_flag <= 1'b0;
    else if (cap)      full_flag <= 1'b1;
    else if (clr_full) full_flag <= 1'b0;
  end

  generate
    if (HAS_OVR) begin : g_ovr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ovr_flag <= 1'b0;
        else if (cap && full_flag && !clr_full)  ovr_flag <= 1'b1;
        else if (clr_ovr)                        ovr_flag <= 1'b0;
      end

      p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap && full_flag && !clr_full |=> ovr_flag);
      p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !clr_ovr |=> ovr_flag);
    end else begin : g_no_ovr
      assign ovr_flag = 1'b0;
    end
  endgenerate

  assign irq_n = !(full_flag && irq_en);

  p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> full_flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_full && !cap |=> !full_flag);
  p_irq_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !full_flag |-> irq_n);
  p_d4_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    d4_mode && mf_boundary && !mode_chg |=> rx_data[BYTE_W-1:D4_W] == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(rx_data));
  p_esf_ignore_mf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !d4_mode && !bit_strobe |=> $stable(rx_data) && $stable(full_flag) || !full_flag);
  p_mode_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> $stable(rx_data));
endmodule

// File: tb/t1_oh_rx_deser_tb.sv
module t1_oh_rx_deser_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d4_mode = 1'b0, rx_bit = 1'b0, bit_strobe = 1'b0, mf_boundary = 1'b0;
  logic clr_full = 1'b0, clr_ovr = 1'b0, irq_en = 1'b0;
  logic [7:0] rx_data;
  logic full_flag, ovr_flag, irq_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  t1_oh_rx_deser u_dut (
    .clk(clk), .rst_n(rst_n), .d4_mode(d4_mode), .rx_bit(rx_bit),
    .bit_strobe(bit_strobe), .mf_boundary(mf_boundary), .clr_full(clr_full),
    .clr_ovr(clr_ovr), .irq_en(irq_en), .rx_data(rx_data),
    .full_flag(full_flag), .ovr_flag(ovr_flag), .irq_n(irq_n));

  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'h01, 8'h80, 8'hA5, 8'h3C, 8'h7E, 8'hBE};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic clr = 1'b0);
    @(negedge clk); rx_bit = b; bit_strobe = 1'b1; clr_full = clr;
    @(negedge clk); bit_strobe = 1'b0; clr_full = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic pulse_clr_full();
    @(negedge clk); clr_full = 1'b1;
    @(negedge clk); clr_full = 1'b0;
  endtask

  task automatic pulse_mf();
    @(negedge clk); mf_boundary = 1'b1;
    @(negedge clk); mf_boundary = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset data", rx_data, 8'h00);
    chk("R8 reset full", full_flag, 1'b0);
    chk("R8 reset ovr", ovr_flag, 1'b0);
    chk("R8 reset irq", irq_n, 1'b1);
    rst_n = 1'b1;
    irq_en = 1'b1;

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 7; i++) send_bit(VEC[v][i]);
      chk("R2 not full before 8th", full_flag, 1'b0);
      send_bit(VEC[v][7]);
      chk("R1 R3 byte", rx_data, VEC[v]);
      chk("R2 full", full_flag, 1'b1);
      chk("R4 irq low", irq_n, 1'b0);
      pulse_clr_full();
      chk("R7 cleared", full_flag, 1'b0);
      chk("R4 irq high", irq_n, 1'b1);
    end

    send_byte(8'h5A);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R4 masked", irq_n, 1'b1);
    irq_en = 1'b1;
    pulse_mf();
    chk("R5 esf ignores mf", rx_data, 8'h5A);
    send_byte(8'hC3);
    chk("R6 overwrite", rx_data, 8'hC3);
    chk("R6 ovr set", ovr_flag, 1'b1);
    @(negedge clk); clr_ovr = 1'b1;
    @(negedge clk); clr_ovr = 1'b0;
    chk("R6 ovr cleared", ovr_flag, 1'b0);
    chk("R8 data held", rx_data, 8'hC3);

    for (int i = 0; i < 7; i++) send_bit(1'b1);
    send_bit(1'b0, 1'b1);
    chk("R7 set wins", full_flag, 1'b1);
    chk("R6 no ovr with clear", ovr_flag, 1'b0);
    chk("R3 raw ones", rx_data, 8'h7F);
    pulse_clr_full();

    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    @(negedge clk); d4_mode = 1'b1;
    @(negedge clk); d4_mode = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    chk("R9 no early byte", full_flag, 1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    chk("R9 restart", rx_data, 8'h00);
    chk("R9 full", full_flag, 1'b1);
    pulse_clr_full();

    @(negedge clk); d4_mode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) send_bit(6'h1C >> i);
    chk("R5 no update before mf", rx_data, 8'h00);
    chk("R5 no full before mf", full_flag, 1'b0);
    pulse_mf();
    chk("R5 fs bits", rx_data, 8'h1C);
    chk("R5 full", full_flag, 1'b1);
    pulse_clr_full();
    for (int i = 0; i < 6; i++) send_bit(6'h23 >> i);
    pulse_mf();
    chk("R5 R1 fs lsb first", rx_data, 8'h23);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    pulse_mf();
    chk("R5 top zero", rx_data, 8'h3F);
    chk("R6 d4 overrun", ovr_flag, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule